// File: doc/BRIEF.md
# Oscillator Wake-up Gate and Core Clock Divider

This block runs on the selected oscillator clock and produces the clock enables for the core and peripheral domains. After reset, after a wake request, or after a source change during start-up, it holds the core enable low for a stabilisation interval. The length of that interval depends on which oscillator source is selected. Crystal sources wait a base count plus a fixed extra margin. The RC source waits a count that models about 250 µs at its nominal frequency. The watchdog oscillator and the external clock wait a short fixed count.

Once the interval has passed, the ready flag goes high and the core enable pulses once per divided period. The period is one oscillator cycle when the divide field is 0, and 2×N cycles otherwise. The peripheral enable pulses on every second core pulse. Software can rewrite the divide field at any time. The new value is applied only when the running period ends, so a period is never cut short. A separate low-power bit is kept and reported, and it does not affect the clocking.

Top module: `osc_wake_divider`

## Requirements
- R1: While reset is asserted, ready, cclk_en, pclk_en and lp_mode are all 0. The stabilisation count starts at the first clock edge after reset is released, so ready first rises D+1 edges after the release, where D is the delay of the selected source.
- R2: The delay D is chosen by src_sel. Codes 0, 1 and 2 (crystal low, medium, high) give XTAL_BASE_CYC+XTAL_EXTRA_CYC. Code 3 (RC) gives RC_CYC. Code 4 (watchdog oscillator) and codes 5 to 7 (external clock) give FAST_CYC. Ready rises exactly D edges after the edge that starts the count.
- R3: cclk_en and pclk_en stay 0 while ready is 0. cclk_en is 1 in the first cycle in which ready is 1.
- R4: If wake_req is seen at an edge while ready is 1, ready is 0 after that edge and the count restarts with the current src_sel.
- R5: If wake_req is seen while the count is running, the count is not restarted and the timing of ready does not change.
- R6: If src_sel differs from the captured source while the count is running, the count restarts from that edge using the new source's delay. A change of src_sel while ready is 1 has no effect.
- R7: When ready is high, with a divide field N, cclk_en pulses every cycle for N=0 and once every 2×N cycles for N from 1 to 255, so N=255 gives a period of 510 cycles.
- R8: A write of the divide field at edge W is used first for the period that begins at the first period boundary at or after edge W+1. Every period already under way completes at its old length.
- R9: pclk_en is asserted together with the 1st, 3rd, 5th and later odd-numbered cclk_en pulses after ready rises, and is 0 at every other time.
- R10: lp_mode resets to 0 and takes lp_wdata on each edge at which lp_we is 1. Its value has no effect on ready, cclk_en or pclk_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Selected oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wake_req | input | 1 | Request to restart the stabilisation wait |
| src_sel | input | 3 | Oscillator source code |
| div_we | input | 1 | Write strobe for the divide field |
| div_wdata | input | DIV_W | New divide field N |
| lp_we | input | 1 | Write strobe for the low-power bit |
| lp_wdata | input | 1 | New low-power bit value |
| cclk_en | output | 1 | Core clock enable, one pulse per divided period |
| pclk_en | output | 1 | Peripheral clock enable, half the core rate |
| ready | output | 1 | Stabilisation wait complete |
| lp_mode | output | 1 | Stored low-power bit |

## Verification
The bench builds the block with a crystal margin of 40 cycles, which gives a crystal wait of 1064 cycles. It uses an RC count of 200, the default short count of 32 and the 8-bit divide field. With these values every source code can be woken several times within the run. The full 510-cycle period at N=255 is covered, including a switch back to N=0 that has to wait for that long period to finish. Divide writes that land in the middle of a period, wake requests during a count, and source changes both during a count and while ready are all compared cycle by cycle against a model built from the requirements.

// File: rtl/osc_wake_divider.sv
module osc_wake_divider #(
  parameter int XTAL_BASE_CYC  = 1024,
  parameter int XTAL_EXTRA_CYC = 640,
  parameter int RC_CYC         = 1843,
  parameter int FAST_CYC       = 32,
  parameter int DIV_W          = 8
) (
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             wake_req,
  input  logic [2:0]       src_sel,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             lp_we,
  input  logic             lp_wdata,
  output logic             cclk_en,
  output logic             pclk_en,
  output logic             ready,
  output logic             lp_mode
);

  localparam int XTAL_CYC = XTAL_BASE_CYC + XTAL_EXTRA_CYC;
  localparam int MAX_A    = (XTAL_CYC > RC_CYC) ? XTAL_CYC : RC_CYC;
  localparam int MAX_D    = (MAX_A > FAST_CYC) ? MAX_A : FAST_CYC;
  localparam int CW       = $clog2(MAX_D + 1);

  function automatic logic [CW-1:0] last_count(input logic [2:0] s);
    case (s)
      3'd0, 3'd1, 3'd2: last_count = CW'(XTAL_CYC - 1);
      3'd3:             last_count = CW'(RC_CYC - 1);
      default:          last_count = CW'(FAST_CYC - 1);
    endcase
  endfunction

  logic          armed;
  logic [2:0]    src_q;
  logic [CW-1:0] cnt;
  logic          ready_q;

  wire start = !armed || (ready_q && wake_req) || (!ready_q && (src_sel != src_q));

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      src_q   <= 3'd0;
      cnt     <= '0;
      ready_q <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (start) begin
        src_q   <= src_sel;
        cnt     <= '0;
        ready_q <= 1'b0;
      end else if (!ready_q) begin
        if (cnt == last_count(src_q)) ready_q <= 1'b1;
        else                          cnt     <= cnt + 1'b1;
      end
    end
  end

  logic [DIV_W-1:0] div_pend, div_act;
  logic [DIV_W:0]   dcnt;
  logic             ph;

  wire [DIV_W:0] lim = (div_act == '0) ? '0 : ({div_act, 1'b0} - 1'b1);

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_pend <= '0;
      div_act  <= '0;
      dcnt     <= '0;
      ph       <= 1'b0;
    end else begin
      if (div_we) div_pend <= div_wdata;
      if (!ready_q) begin
        dcnt    <= '0;
        div_act <= div_pend;
        ph      <= 1'b0;
      end else begin
        if (dcnt == lim) begin
          dcnt    <= '0;
          div_act <= div_pend;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
        if (cclk_en) ph <= ~ph;
      end
    end
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n)     lp_mode <= 1'b0;
    else if (lp_we) lp_mode <= lp_wdata;
  end

  assign ready   = ready_q;
  assign cclk_en = ready_q && (dcnt == '0);
  assign pclk_en = cclk_en && !ph;

  a_r3_enable_needs_ready: assert property (@(posedge osc_clk) disable iff (!rst_n)
    cclk_en |-> ready);

  a_r3_first_pulse_on_ready: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(ready) |-> cclk_en);

  a_r9_pclk_within_cclk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    pclk_en |-> cclk_en);

  a_r4_ready_falls_only_on_wake: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (ready && !wake_req) |=> ready);

  a_r8_no_short_period: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (cclk_en && (div_act != '0)) |=> !cclk_en);

  a_r10_lp_holds: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !lp_we |=> $stable(lp_mode));

endmodule

// File: tb/osc_wake_divider_tb.sv
module osc_wake_divider_tb;

  localparam int XB = 1024, XE = 40, RC = 200, FS = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wake_req = 1'b0;
  logic [2:0] src_sel = 3'd4;
  logic       div_we = 1'b0;
  logic [7:0] div_wdata = 8'd0;
  logic       lp_we = 1'b0;
  logic       lp_wdata = 1'b0;
  logic       cclk_en, pclk_en, ready, lp_mode;

  always #5 clk = ~clk;

  osc_wake_divider #(.XTAL_BASE_CYC(XB), .XTAL_EXTRA_CYC(XE), .RC_CYC(RC),
                     .FAST_CYC(FS), .DIV_W(8)) u_dut (
    .osc_clk(clk), .rst_n(rst_n), .wake_req(wake_req), .src_sel(src_sel),
    .div_we(div_we), .div_wdata(div_wdata), .lp_we(lp_we), .lp_wdata(lp_wdata),
    .cclk_en(cclk_en), .pclk_en(pclk_en), .ready(ready), .lp_mode(lp_mode));

  typedef struct {
    int    cyc;
    logic  rdy, cc, pc, lp;
    string tag;
  } item_t;

  item_t q[$];
  int    compared = 0, mismatched = 0;
  int    cyc = 0;
  string tag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  bit         m_started, m_rdy, m_par, m_pend, m_lp;
  int         m_rdy_at, m_next, m_P, m_apply, m_pendN;
  logic [2:0] m_src;

  function automatic int dly(logic [2:0] s);
    if (s <= 3'd2)      return XB + XE;
    else if (s == 3'd3) return RC;
    else                return FS;
  endfunction

  function automatic void model_step();
    int    c;
    bit    r0, start;
    item_t it;
    c  = cyc + 1;
    r0 = m_rdy;
    start = !m_started || (r0 && wake_req) || (!r0 && (src_sel != m_src));
    m_started = 1;
    if (start) begin
      m_src = src_sel; m_rdy = 0; m_rdy_at = c + dly(src_sel);
    end else if (!r0 && c == m_rdy_at) begin
      m_rdy = 1;
    end
    if (lp_we) m_lp = lp_wdata;
    if (div_we) begin m_pendN = div_wdata; m_pend = 1; m_apply = c + 1; end
    it.cc = 0; it.pc = 0;
    if (m_rdy && (!r0 || c == m_next)) begin
      if (m_pend && c >= m_apply) begin
        m_P = (m_pendN == 0) ? 1 : 2 * m_pendN; m_pend = 0;
      end
      if (!r0) m_par = 0;
      it.cc = 1; it.pc = !m_par; m_par = !m_par; m_next = c + m_P;
    end
    it.cyc = c; it.rdy = m_rdy; it.lp = m_lp; it.tag = tag;
    q.push_back(it);
  endfunction

  item_t e;
  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        e = q.pop_front();
        compared++;
        if (ready !== e.rdy || cclk_en !== e.cc || pclk_en !== e.pc || lp_mode !== e.lp) begin
          mismatched++;
          $display("FAIL %s cycle %0d: rdy/cclk/pclk/lp got %b%b%b%b expected %b%b%b%b",
                   e.tag, cyc, ready, cclk_en, pclk_en, lp_mode, e.rdy, e.cc, e.pc, e.lp);
        end
      end
    end
  end

  task automatic check(bit ok, string req, int got, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    wake_req = 0; div_we = 0; lp_we = 0;
  endtask

  task automatic run(int n);
    repeat (n) begin tick(); model_step(); end
  endtask

  task automatic wake();
    tick(); wake_req = 1; model_step();
  endtask

  task automatic wdiv(int n);
    tick(); div_we = 1; div_wdata = 8'(n); model_step();
  endtask

  task automatic wlp(bit v);
    tick(); lp_we = 1; lp_wdata = v; model_step();
  endtask

  task automatic setsrc(int s);
    tick(); src_sel = 3'(s); model_step();
  endtask

  task automatic do_reset();
    while (q.size() > 0) @(negedge clk);
    tick(); rst_n = 0;
    #1;
    check(ready == 0,   "R1 ready in reset",   int'(ready),   0);
    check(cclk_en == 0, "R1 cclk_en in reset", int'(cclk_en), 0);
    check(pclk_en == 0, "R1 pclk_en in reset", int'(pclk_en), 0);
    check(lp_mode == 0, "R1 lp_mode in reset", int'(lp_mode), 0);
    repeat (3) @(negedge clk);
    m_started = 0; m_rdy = 0; m_lp = 0; m_P = 1; m_pend = 0; m_par = 0; m_src = 0;
    tick(); rst_n = 1; model_step();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    tag = "R1"; do_reset(); run(40);
    tag = "R9"; run(6);
    tag = "R7"; wdiv(1); run(12); wdiv(3); run(20);
    tag = "R8"; wdiv(2); run(3); wdiv(5); run(30);
    tag = "R7"; wdiv(255); run(1100); wdiv(0); run(530);
    tag = "R6"; setsrc(0); run(20);
    tag = "R4"; wake(); run(1070);
    tag = "R2"; setsrc(2); wake(); run(1070);
    setsrc(3); wake(); run(205);
    setsrc(5); wake(); run(40);
    setsrc(7); wdiv(1); wake(); run(40);
    setsrc(1); wake(); run(1070);
    tag = "R5"; setsrc(4); wake(); run(10); wake(); run(10); wake(); run(30);
    tag = "R6"; wake(); run(10); setsrc(3); run(210);
    tag = "R3"; setsrc(6); wdiv(2); wake(); run(45);
    tag = "R10"; wlp(1); run(10); wlp(0); run(5); wlp(1); run(12);
    tag = "R1"; do_reset(); run(40);
    while (q.size() > 0) @(negedge clk);
    summary();
    $finish;
  end

endmodule